// File: doc/BRIEF.md
# Aliased Set/Clear/Toggle Register Bank

This block is a bank of 32-bit control registers on a simple synchronous bus. Each register has four word addresses in a 16-byte slot. The alias used for a write decides how the data updates the stored value:

| Offset | Update |
|--------|--------|
| 0x0 | replace the value |
| 0x4 | set the bits that are 1 in the data |
| 0x8 | clear the bits that are 1 in the data |
| 0xC | invert the bits that are 1 in the data |

Software can therefore change any subset of bits with one write and does not need a read-modify-write sequence.

The number of registers and the address width are parameters. A per-register mask marks bits as read-only. These bits keep their reset value of zero, whatever the write mode. All register values are also driven on a flat output vector so that nearby logic can use them directly.

Slots at or above the register count are unmapped. Writes to them are dropped and reads from them return zero. Reads are combinational: `rd_data` shows the selected register while `rd_en` is high.

Top module: `regbank_alias`

## Requirements
- R1: A synchronous reset clears every register bit to zero; the effect is visible on `regs_out` after the reset edge.
- R2: A write to offset 0x0 of a slot (address bits [3:2] = 0) replaces every writable bit of that register with the write data on the next rising edge.
- R3: A write to offset 0x4 (bits [3:2] = 1) sets to 1 each writable bit whose data bit is 1 and leaves the others unchanged; it never clears a bit.
- R4: A write to offset 0x8 (bits [3:2] = 2) clears each writable bit whose data bit is 1 and leaves the others unchanged; it never sets a bit.
- R5: A write to offset 0xC (bits [3:2] = 3) inverts each writable bit whose data bit is 1 and leaves the others unchanged.
- R6: While `rd_en` is high and the slot is mapped, `rd_data` shows the current value of the register in the same cycle, whichever of the four aliases is used; while `rd_en` is low, `rd_data` is zero.
- R7: A bit that is 1 in `RO_MASK` (register i uses bits [32i+31:32i]) stays zero under all four write modes.
- R8: A write to an unmapped slot (address bits [ADDR_W-1:4] >= NUM_REGS) changes no register.
- R9: A read from an unmapped slot returns zero.
- R10: `regs_out` bits [32i+31:32i] carry register i; when `wr_en` is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates occur on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte address: slot in bits [ADDR_W-1:4], alias in bits [3:2] |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data, used as a value or as a bit mask depending on the alias |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational |
| regs_out | output | NUM_REGS*32 | Current values of all registers, register 0 in the lowest bits |

## Verification
The checker checks these properties on every cycle:
- the reset result;
- that read-only bits stay zero;
- that registers are unchanged when `wr_en` is low or the slot is unmapped;
- that a set write never clears a bit and a clear write never sets one;
- that unmapped or disabled reads return zero.

Only the bench scenarios show the exact values that result:
- the values after replace and toggle writes;
- that a write lands in the addressed register and not in a neighbour;
- that reads through every alias return the same value.

These scenarios compare each step against a bench model under directed and random traffic.

// File: rtl/regbank_alias.sv
module regbank_alias #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [NUM_REGS*32-1:0] RO_MASK = 128'h0000_0000_FF00_0000_0000_0000_8000_0001
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr_en,
  input  logic [31:0]              wr_data,
  input  logic                     rd_en,
  output logic [31:0]              rd_data,
  output logic [NUM_REGS*32-1:0]   regs_out
);
  localparam int unsigned SLOT_W = ADDR_W - 4;
  localparam int unsigned IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [SLOT_W-1:0] slot;
  logic [1:0]        mode;
  logic              mapped;
  logic [31:0]       regs [NUM_REGS];

  assign slot   = addr[ADDR_W-1:4];
  assign mode   = addr[3:2];
  assign mapped = 32'(slot) < 32'(NUM_REGS);

  function automatic logic [31:0] update(input logic [31:0] cur, input logic [31:0] d,
                                         input logic [1:0] m, input logic [31:0] ro);
    logic [31:0] nxt;
    case (m)
      2'd0:    nxt = d;
      2'd1:    nxt = cur | d;
      2'd2:    nxt = cur & ~d;
      default: nxt = cur ^ d;
    endcase
    return (cur & ro) | (nxt & ~ro);
  endfunction

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [31:0] RO = RO_MASK[i*32 +: 32];
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (wr_en && mapped && 32'(slot) == i)
        regs[i] <= update(regs[i], wr_data, mode, RO);
    end
    assign regs_out[i*32 +: 32] = regs[i];
  end

  logic [IDX_W-1:0] ridx;
  assign ridx    = IDX_W'(slot);
  assign rd_data = (rd_en && mapped) ? regs[ridx] : '0;
endmodule

// File: rtl/regbank_alias_chk.sv
module regbank_alias_chk #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [NUM_REGS*32-1:0] RO_MASK = '0
) (
  input logic                   clk,
  input logic                   rst,
  input logic [ADDR_W-1:0]      addr,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [31:0]            rd_data,
  input logic [NUM_REGS*32-1:0] regs_out
);
  logic unmapped;
  assign unmapped = 32'(addr[ADDR_W-1:4]) >= 32'(NUM_REGS);

  assert_reset_zero_R1: assert property (@(posedge clk) rst |=> regs_out == '0);
  assert_set_no_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[3:2] == 2'd1) |=> (($past(regs_out) & ~regs_out) == '0));
  assert_clear_no_set_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[3:2] == 2'd2) |=> ((regs_out & ~$past(regs_out)) == '0));
  assert_read_disabled_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> rd_data == '0);
  assert_ro_zero_R7: assert property (@(posedge clk) rst |=> (regs_out & RO_MASK) == '0);
  assert_ro_hold_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (regs_out & RO_MASK) == '0);
  assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && unmapped) |=> $stable(regs_out));
  assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && unmapped) |-> rd_data == '0);
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_out));
endmodule

bind regbank_alias regbank_alias_chk #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .RO_MASK(RO_MASK)
) i_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .regs_out(regs_out)
);

// File: tb/test_regbank_alias.sv
module test_regbank_alias;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS = 4;
  localparam int AW = 8;
  localparam logic [NREGS*32-1:0] RO = 128'h0000_0000_FF00_0000_0000_0000_8000_0001;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [NREGS*32-1:0] regs_out;
  logic [31:0] model [NREGS];
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regbank_alias #(.NUM_REGS(NREGS), .ADDR_W(AW), .RO_MASK(RO)) i_regbank_alias (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .regs_out(regs_out));

  function automatic logic [31:0] expect_upd(logic [31:0] cur, logic [31:0] d, logic [1:0] m, logic [31:0] ro);
    logic [31:0] n;
    case (m)
      2'd0: n = d;
      2'd1: n = cur | d;
      2'd2: n = cur & ~d;
      default: n = cur ^ d;
    endcase
    return (cur & ro) | (n & ~ro);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < NREGS; i++) check(req, regs_out[i*32 +: 32], model[i]);
  endtask

  task automatic wr(int slot, logic [1:0] m, logic [31:0] d);
    @(negedge clk);
    addr = AW'((slot << 4) | (m << 2));
    wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    if (slot < NREGS) model[slot] = expect_upd(model[slot], d, m, RO[slot*32 +: 32]);
  endtask

  task automatic rd(string req, int slot, logic [1:0] m);
    @(negedge clk);
    addr = AW'((slot << 4) | (m << 2));
    rd_en = 1;
    #1;
    check(req, rd_data, (slot < NREGS) ? model[slot] : 32'h0);
    rd_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_all("R1 reset");

    wr(1, 2'd0, 32'hA5A5_1234); check_all("R2 replace");
    wr(1, 2'd1, 32'h0F00_000F); check_all("R3 set");
    wr(1, 2'd2, 32'hA000_0004); check_all("R4 clear");
    wr(1, 2'd3, 32'hFFFF_0000); check_all("R5 toggle");
    for (int m = 0; m < 4; m++) rd("R6 alias read", 1, 2'(m));
    @(negedge clk); addr = 8'h10; rd_en = 0; #1;
    check("R6 read disabled", rd_data, 32'h0);

    for (int m = 0; m < 4; m++) wr(0, 2'(m), 32'hFFFF_FFFF);
    wr(0, 2'd0, 32'hFFFF_FFFF); check_all("R7 read-only reg0");
    wr(2, 2'd3, 32'hFFFF_FFFF); check_all("R7 read-only reg2");

    wr(5, 2'd0, 32'hDEAD_BEEF); check_all("R8 unmapped write");
    wr(15, 2'd1, 32'hFFFF_FFFF); check_all("R8 unmapped set");
    rd("R9 unmapped read", 7, 2'd0);
    rd("R9 unmapped read", 15, 2'd3);

    @(negedge clk); addr = 8'h00; wr_data = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check_all("R10 idle stable");

    for (int n = 0; n < 400; n++) begin
      int s;
      logic [1:0] m;
      s = int'($urandom_range(0, 15));
      if ($urandom_range(0, 3) != 0) s = s % NREGS;
      m = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) rd("R6 random read", s, m);
      else begin
        wr(s, m, $urandom());
        case (m)
          2'd0: check_all("R2 random");
          2'd1: check_all("R3 random");
          2'd2: check_all("R4 random");
          default: check_all("R5 random");
        endcase
      end
    end

    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    check_all("R1 second reset");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule